// File: doc/BRIEF.md
# Configurable Polarity Host Bus Front-End

This block sits between an external 8-bit host bus and a small internal register file. The host uses a chip select, a read strobe, a write strobe and an acknowledge input. The read and write strobes are separate, and there is no direction line. The strobes are active low. The chip select and the acknowledge each take their active level from a run-time control word, as does the level of the host request outputs.

All host inputs are asynchronous. They pass through a two-flop synchronizer before they are decoded. A write is captured while its strobe is held and is committed to the register file when the strobe is released. During an acknowledge cycle the interrupt vector register is returned on the data bus, and acknowledge overrides any strobe that is asserted at the same time.

The request logic drives one of two arrangements. The first is a single combined request. The second is a transmit-request and receive-request pair. Both arrangements are gated by the port enable and by a request enable.

Top module: `host_bus_frontend`

## Requirements
- R1: While the chip select is active and only the read strobe is low, the bus output enable rises and the data output carries register `host_addr_i`. Address 0 is the request-control register (reset value 0x00). Address 1 is the interrupt vector (reset value 0x0F). Addresses 2 and 3 are scratch registers (reset value 0x00).
- R2: A selected write stores `host_data_i` at `host_addr_i`. The value is committed when the write strobe returns high, and a later read of that address returns it.
- R3: `port_ctrl_i[13]` sets the chip select level: 0 means active low and 1 means active high. A strobe given while the chip select is at its inactive level has no effect.
- R4: `port_ctrl_i[15]` sets the acknowledge level: 0 means active low and 1 means active high. While acknowledge is active, the interrupt vector is driven with the output enable set, whatever the chip select level.
- R5: When acknowledge, read strobe and write strobe are all active together, the vector is returned and no register is written.
- R6: When there is no selected read and no active acknowledge, `host_data_oe_o` is 0.
- R7: A request can be active only when both `port_ctrl_i[0]` (port enable) and control register bit 0 (request enable) are 1. Otherwise every request output sits at its inactive level.
- R8: `port_ctrl_i[14]` sets the request level: 0 drives an active request low and 1 drives it high. The inactive level is the inverse.
- R9: With control register bit 3 at 0 (single mode), `host_req_o` is active when (`rx_full_i` and control bit 1) or (`tx_empty_i` and control bit 2). In this mode the transmit and receive request outputs stay inactive.
- R10: With control bit 3 at 1 (pair mode), `host_treq_o` follows `tx_empty_i` and control bit 2, `host_rreq_o` follows `rx_full_i` and control bit 1, and `host_req_o` stays inactive.
- R11: During and straight after reset the output enable is 0 and all requests are inactive.
- R12: When both strobes are active while selected and acknowledge is inactive, nothing is read and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_ctrl_i | input | 16 | Control word: bit 0 port enable, 13 chip select level, 14 request level, 15 acknowledge level |
| rx_full_i | input | 1 | Receive register full (core side) |
| tx_empty_i | input | 1 | Transmit register empty (core side) |
| host_cs_i | input | 1 | Host chip select, programmable level |
| host_rd_n_i | input | 1 | Host read strobe, active low |
| host_wr_n_i | input | 1 | Host write strobe, active low |
| host_ack_i | input | 1 | Host acknowledge, programmable level |
| host_addr_i | input | 2 | Register address |
| host_data_i | input | 8 | Write data from the host |
| host_data_o | output | 8 | Read or vector data to the host |
| host_data_oe_o | output | 1 | Data bus drive enable (0 = tri-stated) |
| host_req_o | output | 1 | Combined host request |
| host_treq_o | output | 1 | Transmit request (pair mode) |
| host_rreq_o | output | 1 | Receive request (pair mode) |

## Verification
The bus side is tested with selected reads and writes under both chip select levels. Unselected strobes and strobes that overlap are also applied, which separates a correctly gated access from one that leaks through. Acknowledge is applied at both levels, both alone and on top of both strobes, to show that it has priority and blocks writes. The request side is driven through every combination of receive-full and transmit-empty, in single and pair mode, under both output levels and with each enable removed. This shows whether each request routes to the correct line and whether it has the correct level.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;
    // Control word bit positions (port_ctrl_i)
    localparam int PORT_EN_BIT = 0;
    localparam int CS_POL_BIT  = 13;
    localparam int REQ_POL_BIT = 14;
    localparam int ACK_POL_BIT = 15;

    // Request-control register bit positions (register address 0)
    localparam int RC_REQ_EN = 0;
    localparam int RC_RX_EN  = 1;
    localparam int RC_TX_EN  = 2;
    localparam int RC_PAIR   = 3;

    // Register addresses
    localparam int ADDR_RCTL = 0;
    localparam int ADDR_IVEC = 1;

    typedef struct packed {
        logic cs;
        logic rd_n;
        logic wr_n;
        logic ack;
    } host_ctl_t;
endpackage

// File: rtl/hbf_sync.sv
`timescale 1ns/1ps
module hbf_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/hbf_regfile.sv
`timescale 1ns/1ps
module hbf_regfile #(
    parameter int DW = 8,
    parameter int AW = 2,
    parameter logic [DW-1:0] IVEC_RST = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ivec,
    output logic [DW-1:0] rctl
);
    localparam int NREG = 1 << AW;

    logic [NREG-1:0][DW-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= (i == hbf_pkg::ADDR_IVEC) ? IVEC_RST : '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[raddr];
    assign ivec  = regs_q[hbf_pkg::ADDR_IVEC];
    assign rctl  = regs_q[hbf_pkg::ADDR_RCTL];

    // R2: a committed write is visible at its address on the next cycle
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/hbf_bus.sv
`timescale 1ns/1ps
module hbf_bus
    import hbf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  host_ctl_t     ctl,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic          cs_pol,
    input  logic          ack_pol,
    input  logic [DW-1:0] ivec,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] dout,
    output logic          oe
);
    typedef struct packed {
        logic [1:0]    warm;
        logic          pend;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          oe;
        logic [DW-1:0] dout;
    } bus_st_t;

    bus_st_t st_d, st_q;
    logic ready, sel, ack_on, rd_on, wr_on, rd_acc, wr_acc;

    always_comb begin
        ready  = st_q.warm[1];
        sel    = cs_pol ? ctl.cs : ~ctl.cs;
        ack_on = ready & (ack_pol ? ctl.ack : ~ctl.ack);
        rd_on  = ready & sel & ~ctl.rd_n;
        wr_on  = ready & sel & ~ctl.wr_n;
        rd_acc = rd_on & ~wr_on & ~ack_on;
        wr_acc = wr_on & ~rd_on & ~ack_on;

        st_d = st_q;
        we   = 1'b0;
        if (!ready) st_d.warm = st_q.warm + 2'd1;

        if (ack_on || (rd_on && wr_on)) begin
            st_d.pend = 1'b0;
        end else if (wr_acc) begin
            st_d.pend  = 1'b1;
            st_d.waddr = addr;
            st_d.wdata = data;
        end else if (st_q.pend && !wr_on) begin
            we        = 1'b1;
            st_d.pend = 1'b0;
        end

        st_d.oe   = ack_on | rd_acc;
        st_d.dout = ack_on ? ivec : (rd_acc ? rdata : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr = addr;
    assign waddr = st_q.waddr;
    assign wdata = st_q.wdata;
    assign dout  = st_q.dout;
    assign oe    = st_q.oe;

    // R4: an active acknowledge returns the vector on the next cycle
    a_r4_ack_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_on |=> (oe && dout == $past(ivec)));
    // R5: acknowledge blocks any register write
    a_r5_ack_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ack_on |-> !we);
    // R12: overlapping strobes never commit a write or drive the bus
    a_r12_overlap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && wr_on && !ack_on) |=> !oe);
    // R6: drive only after a selected strobe or an acknowledge
    a_r6_drive_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $past(sel || ack_on));
    // R2: a commit happens only once the write strobe is gone
    a_r2_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !wr_on);
endmodule

// File: rtl/hbf_req.sv
`timescale 1ns/1ps
module hbf_req
    import hbf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rctl,
    input  logic          port_en,
    input  logic          req_pol,
    input  logic          rx_full,
    input  logic          tx_empty,
    output logic          req_o,
    output logic          treq_o,
    output logic          rreq_o
);
    localparam int NOUT = 3;   // 0 combined, 1 transmit, 2 receive

    logic [NOUT-1:0] act_d, act_q, lvl;
    logic en, rxc, txc, pair;
    logic unused_rctl;

    assign unused_rctl = ^rctl[DW-1:RC_PAIR+1];

    always_comb begin
        en    = port_en & rctl[RC_REQ_EN];
        rxc   = rx_full & rctl[RC_RX_EN];
        txc   = tx_empty & rctl[RC_TX_EN];
        pair  = rctl[RC_PAIR];
        act_d = act_q;
        act_d[0] = en & ~pair & (rxc | txc);
        act_d[1] = en &  pair & txc;
        act_d[2] = en &  pair & rxc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_lvl
        assign lvl[g] = req_pol ? act_q[g] : ~act_q[g];
    end

    assign req_o  = lvl[0];
    assign treq_o = lvl[1];
    assign rreq_o = lvl[2];

    // R7: without both enables every output is at its inactive level
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (req_o == ~req_pol && treq_o == ~req_pol && rreq_o == ~req_pol));
    // R9: single mode leaves the pair inactive
    a_r9_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pair) |-> (treq_o == ~req_pol && rreq_o == ~req_pol));
    // R10: pair mode leaves the combined line inactive
    a_r10_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pair) |-> req_o == ~req_pol);
endmodule

// File: rtl/host_bus_frontend.sv
`timescale 1ns/1ps
module host_bus_frontend
    import hbf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2,
    parameter int CW = 16,
    parameter logic [DW-1:0] IVEC_RST = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] port_ctrl_i,
    input  logic          rx_full_i,
    input  logic          tx_empty_i,
    input  logic          host_cs_i,
    input  logic          host_rd_n_i,
    input  logic          host_wr_n_i,
    input  logic          host_ack_i,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_data_i,
    output logic [DW-1:0] host_data_o,
    output logic          host_data_oe_o,
    output logic          host_req_o,
    output logic          host_treq_o,
    output logic          host_rreq_o
);
    localparam int CTLW = $bits(host_ctl_t);
    localparam int SW   = CTLW + AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {4'b0110, {(AW+DW){1'b0}}};

    host_ctl_t     ctl_s;
    logic [AW-1:0] addr_s, raddr, waddr;
    logic [DW-1:0] data_s, rdata, ivec, rctl, wdata;
    logic          we;
    logic          unused_ctrl;

    assign unused_ctrl = ^{port_ctrl_i[CW-1:ACK_POL_BIT+1], port_ctrl_i[CS_POL_BIT-1:PORT_EN_BIT+1]};

    hbf_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({host_cs_i, host_rd_n_i, host_wr_n_i, host_ack_i, host_addr_i, host_data_i}),
        .dout ({ctl_s, addr_s, data_s})
    );

    hbf_bus #(.DW(DW), .AW(AW)) i_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl_s),
        .addr   (addr_s),
        .data   (data_s),
        .cs_pol (port_ctrl_i[CS_POL_BIT]),
        .ack_pol(port_ctrl_i[ACK_POL_BIT]),
        .ivec   (ivec),
        .rdata  (rdata),
        .raddr  (raddr),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wdata),
        .dout   (host_data_o),
        .oe     (host_data_oe_o)
    );

    hbf_regfile #(.DW(DW), .AW(AW), .IVEC_RST(IVEC_RST)) i_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(rdata),
        .ivec (ivec),
        .rctl (rctl)
    );

    hbf_req #(.DW(DW)) i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .rctl    (rctl),
        .port_en (port_ctrl_i[PORT_EN_BIT]),
        .req_pol (port_ctrl_i[REQ_POL_BIT]),
        .rx_full (rx_full_i),
        .tx_empty(tx_empty_i),
        .req_o   (host_req_o),
        .treq_o  (host_treq_o),
        .rreq_o  (host_rreq_o)
    );

    // R11: nothing is driven in the first cycle out of reset
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !host_data_oe_o);
endmodule

// File: tb/test_host_bus_frontend.sv
`timescale 1ns/1ps
module test_host_bus_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl = 16'h0000;
    logic        rx_full = 1'b0, tx_empty = 1'b0;
    logic        cs = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ack = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        oe, req, treq, rreq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    host_bus_frontend i_host_bus_frontend (
        .clk(clk), .rst_n(rst_n), .port_ctrl_i(ctrl),
        .rx_full_i(rx_full), .tx_empty_i(tx_empty),
        .host_cs_i(cs), .host_rd_n_i(rd_n), .host_wr_n_i(wr_n), .host_ack_i(ack),
        .host_addr_i(addr), .host_data_i(din),
        .host_data_o(dout), .host_data_oe_o(oe),
        .host_req_o(req), .host_treq_o(treq), .host_rreq_o(rreq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_lines();
        cs = ~ctrl[13]; ack = ~ctrl[15]; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic cs_lvl);
        @(negedge clk);
        addr = a; din = d; cs = cs_lvl; wr_n = 1'b0;
        cyc(4);
        wr_n = 1'b1;
        cyc(4);
        idle_lines();
        cyc(2);
    endtask

    task automatic host_read(input logic [1:0] a, input logic cs_lvl,
                             output logic [7:0] d, output logic e);
        @(negedge clk);
        addr = a; cs = cs_lvl; rd_n = 1'b0;
        cyc(5);
        d = dout; e = oe;
        rd_n = 1'b1;
        cyc(4);
        idle_lines();
        cyc(2);
    endtask

    task automatic t_reset();
        cyc(1);
        chk(oe == 1'b0, "R11 oe in reset", oe, 0);
        rst_n = 1'b1;
        cyc(1);
        chk(oe == 1'b0, "R11 oe after reset", oe, 0);
        chk({req, treq, rreq} == 3'b111, "R11 requests inactive", {req, treq, rreq}, 7);
    endtask

    task automatic t_read_write();
        logic [7:0] d; logic e;
        host_read(2'd1, 1'b0, d, e);
        chk(e && d == 8'h0F, "R1 vector reset value", d, 8'h0F);
        host_write(2'd2, 8'hA5, 1'b0);
        host_read(2'd2, 1'b0, d, e);
        chk(e && d == 8'hA5, "R2 readback scratch2", d, 8'hA5);
        host_write(2'd3, 8'h3C, 1'b0);
        host_read(2'd3, 1'b0, d, e);
        chk(d == 8'h3C, "R2 readback scratch3", d, 8'h3C);
        host_read(2'd2, 1'b0, d, e);
        chk(d == 8'hA5, "R1 scratch2 kept", d, 8'hA5);
        cyc(1);
        chk(oe == 1'b0, "R6 idle no drive", oe, 0);
    endtask

    task automatic t_cs_pol();
        logic [7:0] d; logic e;
        ctrl[13] = 1'b1; idle_lines(); cyc(3);
        host_write(2'd2, 8'h11, 1'b0);
        host_read(2'd2, 1'b1, d, e);
        chk(e && d == 8'hA5, "R3 unselected write ignored", d, 8'hA5);
        host_read(2'd2, 1'b0, d, e);
        chk(e == 1'b0, "R6 unselected read no drive", e, 0);
        host_write(2'd2, 8'h22, 1'b1);
        host_read(2'd2, 1'b1, d, e);
        chk(e && d == 8'h22, "R3 active-high select write", d, 8'h22);
        ctrl[13] = 1'b0; idle_lines(); cyc(3);
    endtask

    task automatic t_ack();
        @(negedge clk); ack = 1'b0; cyc(4);
        chk(oe && dout == 8'h0F, "R4 ack low vector", dout, 8'h0F);
        ack = 1'b1; cyc(4);
        chk(oe == 1'b0, "R6 ack released", oe, 0);
        host_write(2'd1, 8'h5A, 1'b0);
        ctrl[15] = 1'b1; ack = 1'b0; cyc(4);
        chk(oe == 1'b0, "R4 high-level ack idle at 0", oe, 0);
        ack = 1'b1; cyc(4);
        chk(oe && dout == 8'h5A, "R4 ack high vector", dout, 8'h5A);
        ack = 1'b0; cyc(4);
    endtask

    task automatic t_priority();
        logic [7:0] d; logic e;
        @(negedge clk);
        addr = 2'd2; din = 8'hEE; cs = 1'b0; rd_n = 1'b0; wr_n = 1'b0; ack = 1'b1;
        cyc(5);
        chk(oe && dout == 8'h5A, "R5 ack wins", dout, 8'h5A);
        rd_n = 1'b1; wr_n = 1'b1; cyc(2); ack = 1'b0; cyc(4);
        idle_lines(); cyc(2);
        host_read(2'd2, 1'b0, d, e);
        chk(d == 8'h22, "R5 no write under ack", d, 8'h22);
    endtask

    task automatic t_overlap();
        logic [7:0] d; logic e;
        @(negedge clk);
        addr = 2'd2; din = 8'h77; cs = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        cyc(5);
        chk(oe == 1'b0, "R12 overlap no drive", oe, 0);
        rd_n = 1'b1; wr_n = 1'b1; cyc(4);
        idle_lines(); cyc(2);
        host_read(2'd2, 1'b0, d, e);
        chk(d == 8'h22, "R12 overlap no write", d, 8'h22);
    endtask

    task automatic set_flags(input logic rx, input logic tx);
        @(negedge clk); rx_full = rx; tx_empty = tx; cyc(2);
    endtask

    task automatic t_req_single();
        host_write(2'd0, 8'h07, 1'b0);
        cyc(2);
        set_flags(1'b1, 1'b0);
        chk(req == 1'b1, "R7 port disabled keeps inactive", req, 1);
        ctrl[0] = 1'b1; cyc(2);
        chk(req == 1'b0, "R9 rx full asserts low", req, 0);
        chk(treq && rreq, "R9 pair idle in single", {treq, rreq}, 3);
        set_flags(1'b0, 1'b1);
        chk(req == 1'b0, "R9 tx empty asserts", req, 0);
        set_flags(1'b0, 1'b0);
        chk(req == 1'b1, "R9 no condition inactive", req, 1);
        host_write(2'd0, 8'h03, 1'b0);
        set_flags(1'b0, 1'b1);
        chk(req == 1'b1, "R9 tx enable off", req, 1);
        host_write(2'd0, 8'h06, 1'b0);
        set_flags(1'b1, 1'b1);
        chk(req == 1'b1, "R7 request enable off", req, 1);
        host_write(2'd0, 8'h07, 1'b0);
        ctrl[14] = 1'b1; cyc(2);
        chk(req == 1'b1 && treq == 1'b0, "R8 active-high request", {req, treq}, 2);
        ctrl[0] = 1'b0; cyc(2);
        chk(req == 1'b0, "R7 port off with high level", req, 0);
        ctrl[0] = 1'b1; ctrl[14] = 1'b0; cyc(2);
    endtask

    task automatic t_req_pair();
        host_write(2'd0, 8'h0F, 1'b0);
        set_flags(1'b0, 1'b1);
        chk({req, treq, rreq} == 3'b101, "R10 tx only", {req, treq, rreq}, 5);
        set_flags(1'b1, 1'b0);
        chk({req, treq, rreq} == 3'b110, "R10 rx only", {req, treq, rreq}, 6);
        set_flags(1'b1, 1'b1);
        ctrl[14] = 1'b1; cyc(2);
        chk({req, treq, rreq} == 3'b011, "R8 pair active high", {req, treq, rreq}, 3);
        host_write(2'd0, 8'h0B, 1'b0);
        cyc(2);
        chk({req, treq, rreq} == 3'b001, "R10 tx enable off in pair", {req, treq, rreq}, 1);
    endtask

    initial begin
        t_reset();
        t_read_write();
        t_cs_pol();
        t_ack();
        t_priority();
        t_overlap();
        t_req_single();
        t_req_pair();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule